// File: doc/BRIEF.md
# Hierarchical configuration address translator

This block watches the address phase of every transaction on the upstream side of a bus bridge with a set of downstream ports. It recognises a hierarchical (Type 1) configuration access whose bus number names one of the buses attached directly below the bridge. For such an access it builds the local (Type 0) configuration address to be driven on that port, with a one-hot device-select line in the upper address bits.

The caller supplies the 32-bit address, the 4-bit command, a one-cycle address-phase strobe and the secondary bus number of each downstream port. One clock edge later the block presents a hit flag, the index of the chosen port and the rewritten address. Data phases, buffering, arbitration and forwarding to buses further down the hierarchy are handled elsewhere.

The block only translates downstream. It never produces a local configuration address for the upstream side, and it does not act on local configuration requests.

Top module: `cfgx_type1_xlate`

## Requirements
- R1: A hit needs address bits [1:0] equal to 01b. The values 00b, 10b and 11b never hit, so a local configuration request is ignored.
- R2: A hit needs the command to be 1010b (configuration read) or 1011b (configuration write). Every other command gives no hit.
- R3: A hit needs the bus field, address bits [23:16], to equal the secondary bus number of some downstream port. Address bits [31:24] play no part in the decision.
- R4: When more than one port's bus number matches, the lowest port index wins. Port 1 is index 0 and port 2 is index 1.
- R5: On a hit, bits [1:0] of the translated address are 00b.
- R6: On a hit, a device number d in 0 to 15 (address bits [15:11]) sets only bit 16+d among bits [31:16]. A device number in 16 to 31 leaves bits [31:16] all zero.
- R7: On a hit, bits [15:11] of the translated address are zero.
- R8: On a hit, bits [10:2] of the translated address equal bits [10:2] of the incoming address.
- R9: Hit, port index and translated address are registered on the clock edge after the strobe. In any cycle not preceded by a strobe that hits, hit is 0 and both the port index and the translated address are zero.
- R10: A synchronous active-high reset clears hit, port index and translated address to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_valid | input | 1 | Address-phase strobe |
| addr_in | input | 32 | Upstream address |
| cmd_in | input | 4 | Upstream bus command |
| sec_bus_in | input | NUM_PORTS*8 | Secondary bus numbers, port index k in bits [8k+7:8k] |
| xlate_hit | output | 1 | Registered translation hit |
| port_idx | output | PIDX_W | Registered index of the selected downstream port |
| xlate_addr | output | 32 | Registered translated local configuration address |

## Verification
The bench builds the block with its default of NUM_PORTS = 2, which makes the port-priority tie, a match on either port and a mismatch on both reachable with a small set of bus numbers. The command encodings keep their default read and write values, so the bench can test that neighbouring command codes miss. At this width every device number, from a low select line up to the empty range above 15, and every low address-bit code can be driven directly.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

    localparam int ADDR_W  = 32;
    localparam int CMD_W   = 4;
    localparam int BUS_W   = 8;
    localparam int DEV_W   = 5;
    localparam int SEL_W   = 16;

    localparam logic [1:0] KIND_HIER  = 2'b01;
    localparam logic [1:0] KIND_LOCAL = 2'b00;

    // Field view of a hierarchical configuration address
    typedef struct packed {
        logic [7:0]       spare;
        logic [BUS_W-1:0] bus;
        logic [DEV_W-1:0] dev;
        logic [2:0]       fn;
        logic [5:0]       regn;
        logic [1:0]       kind;
    } hier_addr_t;

    // Field view of a local configuration address
    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [DEV_W-1:0] zero_dev;
        logic [2:0]       fn;
        logic [5:0]       regn;
        logic [1:0]       kind;
    } local_addr_t;

    function automatic logic [SEL_W-1:0] dev_to_sel(input logic [DEV_W-1:0] dev);
        logic [SEL_W-1:0] s;
        s = '0;
        for (int i = 0; i < SEL_W; i++) begin
            if (dev == DEV_W'(i)) s[i] = 1'b1;
        end
        return s;
    endfunction

endpackage

// File: rtl/cfgx_req_check.sv
module cfgx_req_check
    import cfgx_pkg::*;
#(
    parameter logic [CMD_W-1:0] CMD_CFG_RD = 4'b1010,
    parameter logic [CMD_W-1:0] CMD_CFG_WR = 4'b1011
) (
    input  hier_addr_t       addr,
    input  logic [CMD_W-1:0] cmd,
    output logic             is_hier_cfg
);
    logic kind_ok;
    logic cmd_ok;

    always_comb begin
        kind_ok     = (addr.kind == KIND_HIER);
        cmd_ok      = (cmd == CMD_CFG_RD) || (cmd == CMD_CFG_WR);
        is_hier_cfg = kind_ok && cmd_ok;
    end
endmodule

// File: rtl/cfgx_bus_match.sv
module cfgx_bus_match
    import cfgx_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    localparam int PIDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic [BUS_W-1:0]           bus,
    input  logic [NUM_PORTS*BUS_W-1:0] sec_bus,
    output logic                       any_match,
    output logic [PIDX_W-1:0]          match_idx
);
    logic [NUM_PORTS-1:0] match_vec;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_cmp
        assign match_vec[p] = (sec_bus[p*BUS_W +: BUS_W] == bus);
    end

    // Lowest index wins: scan from the top so lower entries overwrite
    always_comb begin
        match_idx = '0;
        for (int p = NUM_PORTS - 1; p >= 0; p--) begin
            if (match_vec[p]) match_idx = PIDX_W'(p);
        end
        any_match = |match_vec;
    end
endmodule

// File: rtl/cfgx_addr_rewrite.sv
module cfgx_addr_rewrite
    import cfgx_pkg::*;
(
    input  hier_addr_t  src,
    output local_addr_t dst
);
    always_comb begin
        dst.sel      = dev_to_sel(src.dev);
        dst.zero_dev = '0;
        dst.fn       = src.fn;
        dst.regn     = src.regn;
        dst.kind     = KIND_LOCAL;
    end
endmodule

// File: rtl/cfgx_type1_xlate.sv
module cfgx_type1_xlate
    import cfgx_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter logic [3:0] CMD_CFG_RD = 4'b1010,
    parameter logic [3:0] CMD_CFG_WR = 4'b1011,
    localparam int PIDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       addr_valid,
    input  logic [31:0]                addr_in,
    input  logic [3:0]                 cmd_in,
    input  logic [NUM_PORTS*8-1:0]     sec_bus_in,
    output logic                       xlate_hit,
    output logic [PIDX_W-1:0]          port_idx,
    output logic [31:0]                xlate_addr
);
    hier_addr_t        req;
    local_addr_t       loc;
    logic              is_hier_cfg;
    logic              bus_ok;
    logic [PIDX_W-1:0] idx_d;
    logic              hit_d;

    assign req = hier_addr_t'(addr_in);

    cfgx_req_check #(
        .CMD_CFG_RD(CMD_CFG_RD),
        .CMD_CFG_WR(CMD_CFG_WR)
    ) chk_i (
        .addr        (req),
        .cmd         (cmd_in),
        .is_hier_cfg (is_hier_cfg)
    );

    cfgx_bus_match #(.NUM_PORTS(NUM_PORTS)) match_i (
        .bus       (req.bus),
        .sec_bus   (sec_bus_in),
        .any_match (bus_ok),
        .match_idx (idx_d)
    );

    cfgx_addr_rewrite rew_i (
        .src (req),
        .dst (loc)
    );

    assign hit_d = addr_valid && is_hier_cfg && bus_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            xlate_hit  <= 1'b0;
            port_idx   <= '0;
            xlate_addr <= '0;
        end else begin
            xlate_hit  <= hit_d;
            port_idx   <= hit_d ? idx_d : '0;
            xlate_addr <= hit_d ? 32'(loc) : '0;
        end
    end

    // R5
    hit_kind_local_chk: assert property (@(posedge clk) disable iff (rst)
        xlate_hit |-> (xlate_addr[1:0] == 2'b00));

    // R6
    sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        xlate_hit |-> $onehot0(xlate_addr[31:16]));

    // R7
    dev_field_zero_chk: assert property (@(posedge clk) disable iff (rst)
        xlate_hit |-> (xlate_addr[15:11] == 5'd0));

    // R8
    fn_reg_pass_chk: assert property (@(posedge clk) disable iff (rst)
        addr_valid |=> (!xlate_hit || (xlate_addr[10:2] == $past(addr_in[10:2]))));

    // R9
    hit_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !addr_valid |=> !xlate_hit);

    // R9
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !xlate_hit |-> (xlate_addr == 32'd0 && port_idx == '0));

    // R1
    kind_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_valid && addr_in[1:0] != 2'b01) |=> !xlate_hit);

    // R2
    cmd_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_valid && cmd_in != CMD_CFG_RD && cmd_in != CMD_CFG_WR) |=> !xlate_hit);

    // R6
    sel_range_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_valid && addr_in[15]) |=> (xlate_addr[31:16] == 16'd0));
endmodule

// File: tb/cfgx_type1_xlate_tb_top.sv
module cfgx_type1_xlate_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        addr_valid;
    logic [31:0] addr_in;
    logic [3:0]  cmd_in;
    logic [15:0] sec_bus_in;
    logic        xlate_hit;
    logic [0:0]  port_idx;
    logic [31:0] xlate_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgx_type1_xlate dut_i (
        .clk        (clk),
        .rst        (rst),
        .addr_valid (addr_valid),
        .addr_in    (addr_in),
        .cmd_in     (cmd_in),
        .sec_bus_in (sec_bus_in),
        .xlate_hit  (xlate_hit),
        .port_idx   (port_idx),
        .xlate_addr (xlate_addr)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic [3:0]  cmd;
        logic        hit;
        logic        port;
        logic [31:0] xaddr;
    } vec_t;

    // Bus numbers: index 0 -> 8'h05, index 1 -> 8'h09
    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{32'h0005_1941, 4'hA, 1'b1, 1'b0, 32'h0008_0140}, // R6 dev3, R8
        '{32'h0009_7FFD, 4'hB, 1'b1, 1'b1, 32'h8000_07FC}, // R3 port index 1, dev15
        '{32'h0005_0001, 4'hB, 1'b1, 1'b0, 32'h0001_0000}, // R6 dev0
        '{32'h0005_8211, 4'hA, 1'b1, 1'b0, 32'h0000_0210}, // R6 dev16 no select
        '{32'h0005_F801, 4'hA, 1'b1, 1'b0, 32'h0000_0000}, // R6 dev31, R7
        '{32'h0005_1940, 4'hA, 1'b0, 1'b0, 32'h0000_0000}, // R1 kind 00
        '{32'h0005_1942, 4'hA, 1'b0, 1'b0, 32'h0000_0000}, // R1 kind 10
        '{32'h0005_1943, 4'hB, 1'b0, 1'b0, 32'h0000_0000}, // R1 kind 11
        '{32'h0005_1941, 4'h6, 1'b0, 1'b0, 32'h0000_0000}, // R2 cmd 0110
        '{32'h0005_1941, 4'h8, 1'b0, 1'b0, 32'h0000_0000}, // R2 cmd 1000
        '{32'h0005_1941, 4'hE, 1'b0, 1'b0, 32'h0000_0000}, // R2 cmd 1110
        '{32'h0007_1941, 4'hA, 1'b0, 1'b0, 32'h0000_0000}, // R3 bus mismatch
        '{32'hFF05_1941, 4'hA, 1'b1, 1'b0, 32'h0008_0140}  // R3 upper bits ignored
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] a, input logic [3:0] c);
        @(negedge clk);
        addr_in    = a;
        cmd_in     = c;
        addr_valid = 1'b1;
        @(negedge clk);
        addr_valid = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog act=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst        = 1'b1;
        addr_valid = 1'b0;
        addr_in    = 32'h0005_1941;
        cmd_in     = 4'hA;
        sec_bus_in = {8'h09, 8'h05};
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 hit", 32'(xlate_hit), 32'd0);
        check("R10 addr", xlate_addr, 32'd0);
        check("R10 port", 32'(port_idx), 32'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i].addr, VEC[i].cmd);
            check($sformatf("vec%0d hit", i), 32'(xlate_hit), 32'(VEC[i].hit));
            check($sformatf("vec%0d port", i), 32'(port_idx), 32'(VEC[i].port));
            check($sformatf("vec%0d addr", i), xlate_addr, VEC[i].xaddr);
        end

        // R9: valid request without strobe gives nothing
        @(negedge clk);
        addr_in = 32'h0005_1941; cmd_in = 4'hA;
        @(negedge clk);
        check("R9 no strobe hit", 32'(xlate_hit), 32'd0);
        check("R9 no strobe addr", xlate_addr, 32'd0);

        // R9: output holds one cycle only
        apply(32'h0005_1941, 4'hA);
        check("R9 hit after strobe", 32'(xlate_hit), 32'd1);
        @(negedge clk);
        check("R9 drops next cycle", 32'(xlate_hit), 32'd0);
        check("R9 addr cleared", xlate_addr, 32'd0);

        // R4: both ports match, lowest index wins
        sec_bus_in = {8'h05, 8'h05};
        apply(32'h0005_1941, 4'hB);
        check("R4 tie hit", 32'(xlate_hit), 32'd1);
        check("R4 tie port", 32'(port_idx), 32'd0);
        sec_bus_in = {8'h05, 8'h22};
        apply(32'h0005_1941, 4'hB);
        check("R4 only index1 port", 32'(port_idx), 32'd1);
        check("R4 only index1 addr", xlate_addr, 32'h0008_0140);

        // R10: reset with strobe active clears outputs
        @(negedge clk);
        addr_in = 32'h0005_1941; cmd_in = 4'hA; addr_valid = 1'b1; rst = 1'b1;
        @(negedge clk);
        addr_valid = 1'b0; rst = 1'b0;
        check("R10 reset beats strobe hit", 32'(xlate_hit), 32'd0);
        check("R10 reset beats strobe addr", xlate_addr, 32'd0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule